// File: doc/BRIEF.md
# Staged Reset Sequencer

This block gathers every reason the chip can have to be in reset into one request. It then lets the chip's reset domains come out of reset one after another. There are four reasons. The first is an external reset pin. The second is a power-on condition, raised while any of three supply-good detector inputs is low. The third is a software reset strobe. The fourth is a watchdog timeout strobe. The pin and the detectors are asynchronous. The two strobes are synchronous to the system clock.

Any source drives all four active-low stage resets low at once. For the pin and power-on sources this happens with no clock edge. When the request clears, the clock-generator reset is released first. The system-clocking reset follows after a clock-stabilisation hold. Next come the peripheral reset and then the core reset, each at the edge of a fixed window. Every release falls on a rising clock edge. A source that arrives while the sequence is still running starts the sequence again from the hold stage. A sticky cause register shows which sources caused the latest reset. Software clears its bits by writing ones.

Top module: `rst_stager`

## Requirements
- R1: Driving `ext_rst_n` low sets all four stage resets low at once, without waiting for a clock edge.
- R2: While any bit of `sup_ok` is low, all four stage resets are low, however many clock edges pass.
- R3: After the last asynchronous source clears between two edges, `clkgen_rst_n` rises on the third rising edge that follows (two synchronizer flops, then one output register).
- R4: `sysclk_rst_n` rises HOLD_CYC edges after `clkgen_rst_n`. `periph_rst_n` rises WIN_CYC edges after that. `core_rst_n` rises 2*WIN_CYC edges after `periph_rst_n`. A later stage is never released while an earlier one is held.
- R5: A one-cycle `sw_rst` pulse pulls all stage resets low at the edge that samples it. `clkgen_rst_n` rises on the next edge, and the stage spacing of R4 follows.
- R6: A one-cycle `wdt_rst` pulse behaves in the same way as `sw_rst`.
- R7: A source that asserts while the sequence is still running restarts the sequence from the hold stage, with the full timing of R4.
- R8: `rst_cause` bit 0 means pin, bit 1 means power-on, bit 2 means software and bit 3 means watchdog. A source that starts a reset after `core_rst_n` was released replaces the register with the active sources. Sources that arrive before the core is released are ORed in.
- R9: While the power-on condition holds, `rst_cause` reads 4'b0010.
- R10: A one in a `stat_clr` bit clears that bit of `rst_cause` on the next edge. Zero bits leave the register unchanged. A source that is active in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| sup_ok | input | 3 | Supply detector good flags, asynchronous |
| sw_rst | input | 1 | Software reset strobe, synchronous |
| wdt_rst | input | 1 | Watchdog timeout strobe, synchronous |
| stat_clr | input | 4 | Write-one-to-clear mask for rst_cause |
| clkgen_rst_n | output | 1 | Clock generator reset, active low |
| sysclk_rst_n | output | 1 | System clocking reset, active low |
| periph_rst_n | output | 1 | Peripheral reset, active low |
| core_rst_n | output | 1 | Core reset, active low |
| rst_cause | output | 4 | Sticky reset cause |

## Verification
The bench builds the block with the default HOLD_CYC of 64 and WIN_CYC of 32. This puts the full 64+32+32+32 release timing under test, down to the exact edge. The bench counts release edges from each trigger, so every stage boundary is measured on the full-length windows rather than on shortened ones. These values also leave a long gap between the system-clocking and core releases. A watchdog strobe can land in that gap to show the restart and the ORing of causes.

// File: rtl/rst_stager.sv
module rst_stager #(
  parameter int HOLD_CYC = 64,
  parameter int WIN_CYC  = 32
) (
  input  logic       clk,
  input  logic       ext_rst_n,
  input  logic [2:0] sup_ok,
  input  logic       sw_rst,
  input  logic       wdt_rst,
  input  logic [3:0] stat_clr,
  output logic       clkgen_rst_n,
  output logic       sysclk_rst_n,
  output logic       periph_rst_n,
  output logic       core_rst_n,
  output logic [3:0] rst_cause
);
  localparam int LAST = HOLD_CYC + 3 * WIN_CYC;
  localparam int CW   = $clog2(LAST + 1);
  localparam logic [CW-1:0] T_SYS  = CW'(HOLD_CYC);
  localparam logic [CW-1:0] T_PER  = CW'(HOLD_CYC + WIN_CYC);
  localparam logic [CW-1:0] T_CORE = CW'(LAST);

  logic          pin_raw, por_raw, arst, strobe, live;
  logic [1:0]    pin_ff, por_ff;
  logic [3:0]    src, rst_q, cause_q;
  logic [CW-1:0] cnt;

  assign pin_raw = ~ext_rst_n;
  assign por_raw = ~&sup_ok;
  assign arst    = pin_ff[1] | por_ff[1];
  assign strobe  = sw_rst | wdt_rst;
  assign src     = {wdt_rst, sw_rst, por_ff[1], pin_ff[1]};

  always_ff @(posedge clk or posedge pin_raw)
    if (pin_raw) pin_ff <= 2'b11;
    else         pin_ff <= {pin_ff[0], 1'b0};

  always_ff @(posedge clk or posedge por_raw)
    if (por_raw) por_ff <= 2'b11;
    else         por_ff <= {por_ff[0], 1'b0};

  always_ff @(posedge clk or posedge arst)
    if (arst)                cnt <= '0;
    else if (strobe)         cnt <= '0;
    else if (cnt != T_CORE)  cnt <= cnt + 1'b1;

  always_ff @(posedge clk or posedge arst)
    if (arst)        rst_q <= '0;
    else if (strobe) rst_q <= '0;
    else             rst_q <= {cnt >= T_CORE, cnt >= T_PER, cnt >= T_SYS, 1'b1};

  assign {core_rst_n, periph_rst_n, sysclk_rst_n, clkgen_rst_n} = rst_q;

  always_ff @(posedge clk or posedge por_raw)
    if (por_raw) begin
      live    <= 1'b0;
      cause_q <= 4'b0010;
    end else begin
      live    <= core_rst_n;
      cause_q <= (|src && live) ? src : ((cause_q & ~stat_clr) | src);
    end

  assign rst_cause = cause_q;

  AST_STAGE_ORDER: assert property (@(posedge clk) disable iff (arst)
    (!core_rst_n || periph_rst_n) && (!periph_rst_n || sysclk_rst_n) && (!sysclk_rst_n || clkgen_rst_n)); // R4
  AST_CORE_AFTER_PERIPH: assert property (@(posedge clk) disable iff (arst)
    $rose(core_rst_n) |-> $past(periph_rst_n)); // R4
  AST_STROBE_HOLDS: assert property (@(posedge clk) disable iff (arst)
    strobe |=> !clkgen_rst_n && !core_rst_n); // R5
  AST_CLKGEN_NEXT: assert property (@(posedge clk) disable iff (arst)
    (!clkgen_rst_n && !strobe) |=> clkgen_rst_n); // R3
  AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (por_raw)
    !$stable(rst_cause) |-> $past(|src || |stat_clr)); // R10
endmodule

// File: tb/sim_rst_stager.sv
module sim_rst_stager;
  localparam int PERIOD = 10;
  localparam int HOLD = 64;
  localparam int WIN  = 32;
  localparam int LAST = HOLD + 3 * WIN;

  logic clk = 1'b0;
  logic ext_rst_n, sw_rst, wdt_rst;
  logic [2:0] sup_ok;
  logic [3:0] stat_clr, rst_cause;
  logic clkgen_rst_n, sysclk_rst_n, periph_rst_n, core_rst_n;
  int checks = 0, fails = 0;

  always #(PERIOD/2) clk = ~clk;

  rst_stager #(.HOLD_CYC(HOLD), .WIN_CYC(WIN)) u0 (
    .clk(clk), .ext_rst_n(ext_rst_n), .sup_ok(sup_ok), .sw_rst(sw_rst),
    .wdt_rst(wdt_rst), .stat_clr(stat_clr), .clkgen_rst_n(clkgen_rst_n),
    .sysclk_rst_n(sysclk_rst_n), .periph_rst_n(periph_rst_n),
    .core_rst_n(core_rst_n), .rst_cause(rst_cause));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [3:0] outs();
    return {core_rst_n, periph_rst_n, sysclk_rst_n, clkgen_rst_n};
  endfunction

  task automatic measure(input int base, input string req);
    int first[4];
    int exp[4];
    logic [3:0] o;
    for (int i = 0; i < 4; i++) first[i] = -1;
    exp[0] = base; exp[1] = base + HOLD; exp[2] = base + HOLD + WIN; exp[3] = base + LAST;
    for (int k = 1; k <= LAST + 8; k++) begin
      @(posedge clk); @(negedge clk);
      sw_rst = 1'b0; wdt_rst = 1'b0;
      o = outs();
      for (int i = 0; i < 4; i++) if (first[i] < 0 && o[i]) first[i] = k;
    end
    for (int i = 0; i < 4; i++)
      check(first[i] == exp[i], $sformatf("%s stage%0d", req, i), first[i], exp[i]);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic t_power_on();
    #1;
    check(outs() == 4'b0, "R2 reset state", outs(), 0);
    check(rst_cause == 4'b0010, "R9 cause at power-on", rst_cause, 2);
    idle(5);
    sup_ok = 3'b011;
    idle(10);
    check(outs() == 4'b0, "R2 one detector low", outs(), 0);
    check(rst_cause == 4'b0010, "R9 cause during power-on", rst_cause, 2);
    sup_ok = 3'b111;
    measure(3, "R3 R4 power-on release");
    check(rst_cause == 4'b0010, "R8 cause after power-on", rst_cause, 2);
  endtask

  task automatic t_clear();
    stat_clr = 4'b0001; idle(1); stat_clr = 4'b0;
    check(rst_cause == 4'b0010, "R10 zero bits no effect", rst_cause, 2);
    stat_clr = 4'b0010; idle(1); stat_clr = 4'b0;
    check(rst_cause == 4'b0000, "R10 write one clears", rst_cause, 0);
  endtask

  task automatic t_pin();
    ext_rst_n = 1'b0;
    #1;
    check(outs() == 4'b0, "R1 async pin assertion", outs(), 0);
    idle(3);
    check(rst_cause == 4'b0001, "R8 pin cause", rst_cause, 1);
    ext_rst_n = 1'b1;
    measure(3, "R3 R4 pin release");
  endtask

  task automatic t_sw();
    sw_rst = 1'b1;
    measure(2, "R5 software");
    check(rst_cause == 4'b0100, "R8 software replaces", rst_cause, 4);
  endtask

  task automatic t_wdt();
    wdt_rst = 1'b1;
    measure(2, "R6 watchdog");
    check(rst_cause == 4'b1000, "R8 watchdog replaces", rst_cause, 8);
  endtask

  task automatic t_restart();
    wdt_rst = 1'b1; idle(1); wdt_rst = 1'b0;
    idle(80);
    check(sysclk_rst_n && !periph_rst_n, "R7 mid sequence", outs(), 3);
    sw_rst = 1'b1;
    measure(2, "R7 restart");
    check(rst_cause == 4'b1100, "R8 causes ORed", rst_cause, 12);
    stat_clr = 4'b1000; idle(1); stat_clr = 4'b0;
    check(rst_cause == 4'b0100, "R10 partial clear", rst_cause, 4);
    stat_clr = 4'b0100; sw_rst = 1'b1; idle(1); stat_clr = 4'b0; sw_rst = 1'b0;
    check(rst_cause == 4'b0100, "R10 set wins over clear", rst_cause, 4);
    idle(LAST + 4);
  endtask

  task automatic t_por_mid();
    sw_rst = 1'b1; idle(1); sw_rst = 1'b0;
    idle(100);
    sup_ok = 3'b101;
    #1;
    check(outs() == 4'b0, "R2 async power-on mid sequence", outs(), 0);
    idle(2);
    sup_ok = 3'b111;
    measure(3, "R7 R4 power-on restart");
  endtask

  initial begin
    ext_rst_n = 1'b1; sup_ok = 3'b000; sw_rst = 1'b0; wdt_rst = 1'b0; stat_clr = 4'b0;
    t_power_on();
    t_clear();
    t_pin();
    t_sw();
    t_wdt();
    t_restart();
    t_por_mid();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule